// File: doc/BRIEF.md
# Column-Wise Carry-Save Row Summer

This combinational block adds a fixed number of equal-width binary rows, typically the aligned partial products of a multiplier, and returns their total modulo two to the width. Each bit column is compressed on its own by layers of full and half adders until it holds at most one sum bit. Every carry a compressor makes is pushed into the pool of the column above. One carry per column is kept back as that column's carry result.

The kept sum bits and carry bits form two vectors. The carry vector is moved up one place, with a zero entering at bit 0. A parallel-prefix lookahead adder, with no carry in, then combines the two vectors into the result. The row count and width are parameters. Rows arrive packed into one flat input vector.

Top module: `csa_column_reducer`

## Requirements
- R1: `total_o` equals the sum of all NUM_ROWS rows taken modulo 2^WIDTH, for any input pattern.
- R2: Row r occupies bits [r*WIDTH +: WIDTH] of `rows_i`, with the row's LSB at the lowest index.
- R3: Any carry beyond bit WIDTH-1 is dropped: rows that are all ones give (-NUM_ROWS) mod 2^WIDTH, and an all-ones row plus a row holding 1 gives 0.
- R4: When every row is zero, `total_o` is zero.
- R5: Bit 0 of `total_o` is the XOR of bit 0 of every row, since column 0 receives no carries.
- R6: The compressed sum vector plus the carry vector shifted up by one equals the row total modulo 2^WIDTH.
- R7: The lookahead adder's result and its carry out of the top bit equal the plain sum of the sum vector and the shifted carry vector, and no carry is generated in a column whose prefix propagates across the full word.
- R8: R1 holds for every row count from 3 to 8 at the same width.
- R9: When only one row is non-zero, `total_o` equals that row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rows_i | input | NUM_ROWS*WIDTH | Flat array of rows, row r at bits [r*WIDTH +: WIDTH] |
| total_o | output | WIDTH | Sum of all rows modulo 2^WIDTH |

## Verification
The hardest case to reach is a column pool at its largest size, where every row and every incoming carry is a one. There the layered grouping passes through full adders, a half adder and pass-through bits in the same column. All-ones rows are applied at every row count from 3 to 8 to force this case. A second hard case is a carry that travels through the whole lookahead tree. This is reached with a wrap pattern: an all-ones row plus a row holding 1, which must give zero. One-hot row patterns and long random runs then cover the row placement and the ordinary mixes.

// File: rtl/csa_column_reducer.sv
module csa_column_reducer #(
  parameter int NUM_ROWS = 4,
  parameter int WIDTH    = 12
) (
  input  logic [NUM_ROWS*WIDTH-1:0] rows_i,
  output logic [WIDTH-1:0]          total_o
);
  localparam int POOL   = NUM_ROWS + WIDTH * NUM_ROWS;
  localparam int LAYERS = 2 * $clog2(POOL) + 2;
  localparam int LVLS   = $clog2(WIDTH);

  logic [WIDTH-1:0] sum_v, cry_v, cry_sh, gen_v, prop_v;

  always_comb begin
    logic [POOL+2:0] pool, nxt;
    logic [POOL-1:0] cq, cq_next;
    int pn, nn, cn, cnn;
    cq = '0;
    cn = 0;
    sum_v = '0;
    cry_v = '0;
    for (int col = 0; col < WIDTH; col++) begin
      pool = '0;
      pn = 0;
      for (int r = 0; r < NUM_ROWS; r++) begin
        pool[pn] = rows_i[r*WIDTH+col];
        pn++;
      end
      for (int j = 0; j < POOL; j++) begin
        if (j < cn) begin
          pool[pn] = cq[j];
          pn++;
        end
      end
      cq_next = '0;
      cnn = 0;
      for (int layer = 0; layer < LAYERS; layer++) begin
        if (pn > 1) begin
          nxt = '0;
          nn = 0;
          for (int i = 0; i < POOL; i += 3) begin
            if (i + 2 < pn) begin
              nxt[nn] = pool[i] ^ pool[i+1] ^ pool[i+2];
              cq_next[cnn] = (pool[i] & pool[i+1]) | (pool[i+2] & (pool[i] | pool[i+1]));
              nn++;
              cnn++;
            end else if (i + 1 < pn) begin
              nxt[nn] = pool[i] ^ pool[i+1];
              cq_next[cnn] = pool[i] & pool[i+1];
              nn++;
              cnn++;
            end else if (i < pn) begin
              nxt[nn] = pool[i];
              nn++;
            end
          end
          pool = nxt;
          pn = nn;
        end
      end
      sum_v[col] = (pn == 1) ? pool[0] : 1'b0;
      if (cnn > 0) begin
        cry_v[col] = cq_next[cnn-1];
        cq_next[cnn-1] = 1'b0;
        cnn--;
      end
      cq = cq_next;
      cn = cnn;
    end
  end

  assign cry_sh = {cry_v[WIDTH-2:0], 1'b0};
  assign gen_v  = sum_v & cry_sh;
  assign prop_v = sum_v ^ cry_sh;

  logic [WIDTH-1:0] gg [LVLS+1];
  logic [WIDTH-1:0] pp [LVLS];
  assign gg[0] = gen_v;
  assign pp[0] = prop_v;

  for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
    localparam int DIST = 1 << (l - 1);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (b >= DIST) begin : g_merge
        assign gg[l][b] = gg[l-1][b] | (pp[l-1][b] & gg[l-1][b-DIST]);
        if (l < LVLS) begin : g_p
          assign pp[l][b] = pp[l-1][b] & pp[l-1][b-DIST];
        end
      end else begin : g_pass
        assign gg[l][b] = gg[l-1][b];
        if (l < LVLS) begin : g_p
          assign pp[l][b] = pp[l-1][b];
        end
      end
    end
  end

  assign total_o = prop_v ^ {gg[LVLS][WIDTH-2:0], 1'b0};

  always_comb begin
    logic [WIDTH-1:0] ref_tot;
    logic [WIDTH:0]   wide;
    logic             par0;
    ref_tot = '0;
    par0 = 1'b0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      ref_tot = ref_tot + rows_i[r*WIDTH +: WIDTH];
      par0 = par0 ^ rows_i[r*WIDTH];
    end
    wide = {1'b0, sum_v} + {1'b0, cry_sh};
    if (!$isunknown(rows_i)) begin
      assert_row_total_R1: assert (total_o == ref_tot)
        else $error("R1 total mismatch");
      assert_lsb_parity_R5: assert (total_o[0] == par0)
        else $error("R5 lsb parity mismatch");
      assert_tree_value_R6: assert ((sum_v + {cry_v[WIDTH-2:0], 1'b0}) == ref_tot)
        else $error("R6 carry-save value mismatch");
      assert_final_add_R7: assert ({gg[LVLS][WIDTH-1], total_o} == wide)
        else $error("R7 lookahead sum mismatch");
      assert_no_carry_full_prop_R7: assert (!(&pp[LVLS-1]) || (gg[LVLS] == '0))
        else $error("R7 carry under full propagate");
    end
  end
endmodule

// File: tb/sim_csa_column_reducer.sv
module sim_csa_column_reducer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int N0 = 4;
  localparam int MAXN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [MAXN*W-1:0] stim = '0;
  logic [W-1:0] out0;
  logic [W-1:0] outs [6];
  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csa_column_reducer #(.NUM_ROWS(N0), .WIDTH(W)) u0 (
    .rows_i(stim[N0*W-1:0]), .total_o(out0));

  for (genvar g = 0; g < 6; g++) begin : g_var
    csa_column_reducer #(.NUM_ROWS(g+3), .WIDTH(W)) u_var (
      .rows_i(stim[(g+3)*W-1:0]), .total_o(outs[g]));
  end

  function automatic logic [W-1:0] expect_sum(int n);
    int acc = 0;
    for (int r = 0; r < n; r++) acc += int'(stim[r*W +: W]);
    return W'(acc % (1 << W));
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, out0, expect_sum(N0));
    for (int g = 0; g < 6; g++) check({req, " R8"}, outs[g], expect_sum(g+3));
  endtask

  task automatic apply(logic [MAXN*W-1:0] v, string req);
    @(posedge clk);
    stim = v;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 reset state zero", out0, '0);
    apply('0, "R4 all rows zero");
    apply('1, "R3 all ones wrap");
    for (int g = 0; g < 6; g++)
      check("R3 all-ones", outs[g], W'((1 << W) - (g + 3)));
    apply({{(MAXN-2)*W{1'b0}}, W'(1), {W{1'b1}}}, "R3 carry across word");
    check("R3 wrap to zero", out0, '0);
    for (int r = 0; r < MAXN; r++) begin
      logic [MAXN*W-1:0] v;
      logic [W-1:0] val;
      v = '0;
      val = W'($urandom) | W'(1);
      v[r*W +: W] = val;
      apply(v, "R9 R2 single row");
      if (r < N0) check("R9 single row equals row", out0, val);
    end
    for (int k = 0; k < 300; k++) begin
      logic [MAXN*W-1:0] v;
      logic p;
      for (int j = 0; j < MAXN; j++) v[j*W +: W] = W'($urandom);
      apply(v, "R1 random");
      p = 1'b0;
      for (int r = 0; r < N0; r++) p ^= v[r*W];
      tests++;
      if (out0[0] !== p) begin
        fails++;
        $display("FAIL R5: actual %0b expected %0b", out0[0], p);
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule